// File: doc/BRIEF.md
# Indexed Super I/O Configuration Decoder

This block holds the configuration registers of a legacy Super I/O function and decodes an 8-bit I/O bus with them. Software writes a register number to a fixed index port, then reads or writes that register through the data port at the next address. One of the registers turns the serial port on and off, and another relocates it within the I/O space.

Once the serial port is enabled, the block claims a 16-byte window. It drives a chip select to an external UART for the low eight bytes of the window. Bytes eight and nine hold a 16-bit baud divisor, which is stored here. An active copy of the divisor drives the clock scaling, and it ignores a zero divisor. Read data is returned in the same cycle as the read strobe. A write takes effect at the next clock edge.

Top module: `sio_cfg_decoder`

## Requirements
- R1: A write to I/O address 0x3F0 keeps only bits 3:0 of the data as the register index. A read of 0x3F0 returns that index zero-extended to 8 bits. All 11 address bits are compared, so 0x7F0 is not the index port.
- R2: A read of 0x3F1 returns the register selected by the index. A write to 0x3F1 stores the byte into that register, and a read in the following cycle returns the new value.
- R3: Registers 0 and 1 always read 0x3C and 0x01, and writes to them change nothing.
- R4: After reset the index is 0, register 2 is 0x03, register 4 is 0xFE, register 6 is 0xDE, register 7 is 0xFC, and every other register is 0x00. The baud divisor and its active copy are both 1.
- R5: Bit 2 of register 2 enables the serial window. The window starts at register 4 multiplied by four (0xFE gives 0x3F8) and spans 16 bytes. While bit 2 is clear, no address is claimed by the window.
- R6: `uart_cs` is high in the same cycle as a read or write strobe whose address falls at window offsets 0 to 7, and it is low otherwise.
- R7: A write to window offset 8 replaces bits 7:0 of the baud divisor, and a write to offset 9 replaces bits 15:8, each without touching the other byte. A read of offset 8 or 9 returns the matching byte.
- R8: After a divisor write, the active divisor takes the new stored value if that value is non-zero. If the stored value is zero, the active divisor keeps its previous value.
- R9: A write to register 2 or register 4 changes the decoding of the very next access.
- R10: A read of any address not claimed by the index port, the data port or the divisor bytes returns 0xFF. This includes window offsets 0 to 7 and 10 to 15. `io_rdata` is 0xFF whenever `io_rd` is low. The index and data ports take priority over an overlapping serial window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 11 | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the current address |
| uart_cs | output | 1 | Chip select for the UART at window offsets 0-7 |
| baud_div | output | 16 | Stored baud divisor |
| baud_active | output | 16 | Divisor in effect for clock scaling, never zero |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle, and that each access lasts exactly one cycle with a stable address. The bench drives one access per cycle, always with at most one strobe set. Random accesses are aimed at the current window, as the reference model sees it, and at the configuration ports. Random data writes can move the window onto the configuration ports or disable it, and the model follows those changes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int CFG_REGS     = 16;
    localparam int CFG_IDX_W    = $clog2(CFG_REGS);
    localparam int CFG_RO       = 2;
    localparam int REG_FUNC     = 2;
    localparam int REG_SER_BASE = 4;
    localparam int SER_EN_BIT   = 2;
    localparam int BASE_SHIFT   = 2;
    localparam int WIN_BYTES    = 16;
    localparam int UART_BYTES   = 8;
    localparam int DIV_OFF      = 8;
    localparam int DIV_BYTES    = 2;
    localparam int DIV_W        = 8 * DIV_BYTES;

    typedef logic [CFG_REGS-1:0][7:0] cfg_bank_t;

    typedef struct packed {
        logic [CFG_IDX_W-1:0] idx;
        cfg_bank_t            bank;
    } cfg_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] stored;
        logic [DIV_W-1:0] active;
    } div_state_t;

    typedef struct packed {
        logic                 idx_port;
        logic                 data_port;
        logic                 uart;
        logic [DIV_BYTES-1:0] div_byte;
    } hit_t;

    function automatic logic [7:0] cfg_reset_value(input int unsigned i);
        case (i)
            0:       return 8'h3C;
            1:       return 8'h01;
            2:       return 8'h03;
            4:       return 8'hFE;
            6:       return 8'hDE;
            7:       return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_wr,
    input  logic                 data_wr,
    input  logic [7:0]           wdata,
    output logic [CFG_IDX_W-1:0] idx_q,
    output cfg_bank_t            bank_q
);

    cfg_state_t state_d, state_q;

    function automatic cfg_state_t reset_state();
        cfg_state_t s;
        s.idx = '0;
        for (int i = 0; i < CFG_REGS; i++) s.bank[i] = cfg_reset_value(i);
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        if (idx_wr) state_d.idx = wdata[CFG_IDX_W-1:0];
        if (data_wr && (int'(state_q.idx) >= CFG_RO))
            state_d.bank[state_q.idx] = wdata;
        for (int i = 0; i < CFG_RO; i++) state_d.bank[i] = cfg_reset_value(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    assign idx_q  = state_q.idx;
    assign bank_q = state_q.bank;

endmodule

// File: rtl/sio_baud_div.sv
module sio_baud_div
    import sio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_BYTES-1:0] byte_wr,
    input  logic [7:0]           wdata,
    output logic [DIV_W-1:0]     stored_q,
    output logic [DIV_W-1:0]     active_q
);

    div_state_t div_d, div_q;
    logic [DIV_W-1:0] cand;

    always_comb begin
        cand = div_q.stored;
        for (int b = 0; b < DIV_BYTES; b++)
            if (byte_wr[b]) cand[8*b +: 8] = wdata;
        div_d        = div_q;
        div_d.stored = cand;
        if ((|byte_wr) && (cand != '0)) div_d.active = cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.stored <= DIV_W'(1);
            div_q.active <= DIV_W'(1);
        end else begin
            div_q <= div_d;
        end
    end

    assign stored_q = div_q.stored;
    assign active_q = div_q.active;

endmodule

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(11'h3F0)
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              ser_en,
    input  logic [7:0]        ser_base,
    output hit_t              hit
);

    localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + ADDR_W'(1);

    logic [ADDR_W-1:0] base, off;
    logic              in_win, cfg_port, access;

    always_comb begin
        base     = ADDR_W'(ser_base) << BASE_SHIFT;
        off      = io_addr - base;
        access   = io_rd | io_wr;
        cfg_port = (io_addr == IDX_PORT) || (io_addr == DATA_PORT);
        in_win   = ser_en && (io_addr >= base) && (off < ADDR_W'(WIN_BYTES)) && !cfg_port;

        hit.idx_port  = (io_addr == IDX_PORT);
        hit.data_port = (io_addr == DATA_PORT);
        hit.uart      = access && in_win && (off < ADDR_W'(UART_BYTES));
        for (int b = 0; b < DIV_BYTES; b++)
            hit.div_byte[b] = in_win && (off == ADDR_W'(DIV_OFF + b));
    end

endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(11'h3F0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              uart_cs,
    output logic [DIV_W-1:0]  baud_div,
    output logic [DIV_W-1:0]  baud_active
);

    hit_t                 hit;
    logic [CFG_IDX_W-1:0] idx_q;
    cfg_bank_t            bank_q;
    logic                 ser_en;
    logic [DIV_BYTES-1:0] div_wr;

    assign ser_en = bank_q[REG_FUNC][SER_EN_BIT];
    assign div_wr = io_wr ? hit.div_byte : '0;

    sio_addr_decode #(.ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT)) i_dec (
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .ser_en   (ser_en),
        .ser_base (bank_q[REG_SER_BASE]),
        .hit      (hit)
    );

    sio_cfg_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (io_wr && hit.idx_port),
        .data_wr (io_wr && hit.data_port),
        .wdata   (io_wdata),
        .idx_q   (idx_q),
        .bank_q  (bank_q)
    );

    sio_baud_div i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_wr  (div_wr),
        .wdata    (io_wdata),
        .stored_q (baud_div),
        .active_q (baud_active)
    );

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd) begin
            if (hit.idx_port)       io_rdata = 8'(idx_q);
            else if (hit.data_port) io_rdata = bank_q[idx_q];
            else begin
                for (int b = 0; b < DIV_BYTES; b++)
                    if (hit.div_byte[b]) io_rdata = baud_div[8*b +: 8];
            end
        end
    end

    assign uart_cs = hit.uart;

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker
    import sio_cfg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [7:0]           io_rdata,
    input logic                 uart_cs,
    input logic [DIV_W-1:0]     baud_div,
    input logic [DIV_W-1:0]     baud_active,
    input logic [CFG_IDX_W-1:0] idx_q,
    input logic                 ser_en
);

    p_idx_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == ADDR_W'(11'h3F0)) |-> (io_rdata[7:4] == 4'h0));

    p_ro_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == ADDR_W'(11'h3F1) && idx_q == '0) |-> (io_rdata == 8'h3C));

    p_cs_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uart_cs |-> ser_en);

    p_cs_needs_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uart_cs |-> (io_rd || io_wr));

    p_active_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_active != '0);

    p_active_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(baud_active) |-> (baud_active == baud_div));

    p_cs_reads_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && uart_cs) |-> (io_rdata == 8'hFF));

    p_cfg_port_no_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_W'(11'h3F0)) |-> !uart_cs);

endmodule

bind sio_cfg_decoder sio_cfg_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_rdata    (io_rdata),
    .uart_cs     (uart_cs),
    .baud_div    (baud_div),
    .baud_active (baud_active),
    .idx_q       (idx_q),
    .ser_en      (ser_en)
);

// File: tb/test_sio_cfg_decoder.sv
module test_sio_cfg_decoder;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        uart_cs;
    logic [15:0] baud_div;
    logic [15:0] baud_active;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    int m_cfg[16];
    int m_idx, m_div, m_act;

    always #(PER/2) clk = ~clk;

    sio_cfg_decoder i_sio_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .uart_cs(uart_cs),
        .baud_div(baud_div), .baud_active(baud_active)
    );

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_cfg[i] = 0;
        m_cfg[0] = 'h3C; m_cfg[1] = 'h01; m_cfg[2] = 'h03;
        m_cfg[4] = 'hFE; m_cfg[6] = 'hDE; m_cfg[7] = 'hFC;
        m_idx = 0; m_div = 1; m_act = 1;
    endtask

    function automatic int win_off(input int a);
        int base;
        base = m_cfg[4] * 4;
        if (a == 'h3F0 || a == 'h3F1) return -1;
        if ((m_cfg[2] & 4) == 0) return -1;
        if (a < base || a >= base + 16) return -1;
        return a - base;
    endfunction

    task automatic check(input int got, input int exp, input string tag, input string what);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input int a, input bit wr, input bit rd, input int wd, input string tag);
        int off, exp_rd;
        bit exp_cs;
        @(negedge clk);
        io_addr = 11'(a); io_wr = wr; io_rd = rd; io_wdata = 8'(wd);
        #(PER/4);
        off = win_off(a);
        exp_rd = 'hFF;
        if (rd) begin
            if (a == 'h3F0)      exp_rd = m_idx;
            else if (a == 'h3F1) exp_rd = m_cfg[m_idx];
            else if (off == 8)   exp_rd = m_div & 'hFF;
            else if (off == 9)   exp_rd = (m_div >> 8) & 'hFF;
        end
        exp_cs = (rd || wr) && off >= 0 && off < 8;
        check(io_rdata, exp_rd, tag, "io_rdata");
        check(uart_cs, exp_cs, tag, "uart_cs");
        check(baud_div, m_div, tag, "baud_div");
        check(baud_active, m_act, tag, "baud_active");
        @(posedge clk);
        if (wr && rst_n) begin
            if (a == 'h3F0) m_idx = wd & 'hF;
            else if (a == 'h3F1) begin
                if (m_idx >= 2) m_cfg[m_idx] = wd & 'hFF;
            end else if (off == 8 || off == 9) begin
                if (off == 8) m_div = (m_div & 'hFF00) | (wd & 'hFF);
                else          m_div = (m_div & 'h00FF) | ((wd & 'hFF) << 8);
                if (m_div != 0) m_act = m_div;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(PER * 150000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        // R4: reset state, register 0 readable through the data port during reset
        step('h3F1, 0, 1, 0, "R4");
        @(negedge clk); rst_n = 1'b1;
        // R4: all reset defaults
        for (int i = 0; i < 16; i++) begin
            step('h3F0, 1, 0, i, "R1");
            step('h3F1, 0, 1, 0, "R4");
        end
        // R1: index keeps low nibble; 0x7F0 is not the index port
        step('h3F0, 1, 0, 'hF7, "R1");
        step('h3F0, 0, 1, 0, "R1");
        step('h7F0, 1, 0, 'h03, "R1");
        step('h3F0, 0, 1, 0, "R1");
        // R3: read-only registers
        step('h3F0, 1, 0, 0, "R3");
        step('h3F1, 1, 0, 'h55, "R3");
        step('h3F1, 0, 1, 0, "R3");
        step('h3F0, 1, 0, 1, "R3");
        step('h3F1, 1, 0, 'hAA, "R3");
        step('h3F1, 0, 1, 0, "R3");
        // R2: writable register round trip
        step('h3F0, 1, 0, 9, "R2");
        step('h3F1, 1, 0, 'h5A, "R2");
        step('h3F1, 0, 1, 0, "R2");
        // R6 / R10: default window at 0x3F8
        for (int o = 0; o < 16; o++) step('h3F8 + o, 0, 1, 0, "R6");
        step('h3F8, 1, 0, 'h41, "R6");
        step('h3F7, 0, 1, 0, "R10");
        step('h3F8, 0, 0, 0, "R6");
        // R7 / R8: divisor bytes and zero handling
        step('h400, 1, 0, 'h00, "R8");
        step('h400, 0, 1, 0, "R7");
        step('h401, 1, 0, 'h02, "R7");
        step('h401, 0, 1, 0, "R7");
        step('h401, 1, 0, 'h00, "R8");
        step('h400, 1, 0, 'h0C, "R8");
        step('h400, 0, 1, 0, "R7");
        // R9 / R5: relocate window to 0x100, then disable it
        step('h3F0, 1, 0, 4, "R9");
        step('h3F1, 1, 0, 'h40, "R9");
        step('h100, 0, 1, 0, "R9");
        step('h3F8, 0, 1, 0, "R9");
        step('h108, 0, 1, 0, "R5");
        step('h3F0, 1, 0, 2, "R5");
        step('h3F1, 1, 0, 'h10, "R5");
        step('h100, 0, 1, 0, "R5");
        step('h108, 0, 1, 0, "R5");
        step('h108, 1, 0, 'h33, "R5");
        step('h3F1, 1, 0, 'h07, "R9");
        step('h104, 1, 0, 0, "R9");
        // R10: window moved over the configuration ports
        step('h3F0, 1, 0, 4, "R10");
        step('h3F1, 1, 0, 'hFC, "R10");
        step('h3F0, 0, 1, 0, "R10");
        step('h3F1, 0, 1, 0, "R10");
        step('h3F2, 0, 1, 0, "R10");
        step('h3F8, 0, 1, 0, "R10");
        // mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int base, v;
            base = m_cfg[4] * 4;
            case ($urandom % 8)
                0: step('h3F0, 1, 0, int'($urandom % 256), "R1");
                1: begin
                    v = int'($urandom % 256);
                    if (m_idx == 2 && ($urandom % 2) == 1) v = v | 4;
                    step('h3F1, 1, 0, v, "R2");
                end
                2: step('h3F1, 0, 1, 0, "R2");
                3: step(base + int'($urandom % 16), 0, 1, 0, "R6");
                4: step(base + 8 + int'($urandom % 2), 1, 0,
                        (($urandom % 4) == 0) ? 0 : int'($urandom % 256), "R8");
                5: begin
                    bit w;
                    w = 1'($urandom % 2);
                    step(int'($urandom % 2048), w, !w, int'($urandom % 256), "R10");
                end
                6: step('h3F0, 0, 1, 0, "R1");
                default: step(base + int'($urandom % 16), 1, 0, int'($urandom % 256), "R7");
            endcase
        end
        finish_run();
    end

endmodule